// File: doc/BRIEF.md
# Sequential Pattern Trigger Unit

This block sits beside a probe bus inside a chip and decides when a capture engine should take its trigger. On every rising edge of the sample clock it compares the probe bus against the pattern of the trigger level it is currently waiting for. A level is a set of per-signal conditions: a signal may be required low, required high, or left free. The level holds only when every condition holds in the same sample. Levels are worked through in order, one at most per sample. Once the last configured level holds, the trigger event is raised and the unit stops until it is armed again.

A global per-signal enable mask removes chosen signals from every comparison. An optional external trigger input, active low, can gate the final level. An active-low trigger output pulses for one sample-clock cycle, a fixed four cycles after the sample that completed the chain. Software-side setup arrives through a plain register-write port. The probe bus has no handshake: a new sample is taken on every clock and nothing can be stalled, so there is no back-pressure at any edge of the block. The pattern field needs at least three probe signals (`NSIG >= 3`). `MAXLVL` must not exceed `2**AW - 2`.

Top module: `seqtrig_top`

## Requirements
- R1: After a synchronous reset, `trig_out_n` is 1, `armed` is 0 and `level` reads 1. All patterns are cleared to "free", the mask is 0, the level count is 1 and trigger-in gating is off.
- R2: A cycle with `arm` high sets `armed` to 1 and `level` to 1 at the next edge. This applies mid-chain as well, and `arm` takes priority over any match in the same sample.
- R3: Pattern register `a` (addresses 0 to MAXLVL-1) holds level a+1. Bits [2i+1:2i] give the condition for probe bit i: 00 free, 01 must be low, 10 must be high, 11 free. A level holds only when all enabled conditions hold in the same sample.
- R4: Mask register, address 2**AW-2, bits [NSIG-1:0]. A probe bit whose mask bit is 0 is free in every level.
- R5: Levels are satisfied in order, advancing at most one level per sample. A sample that satisfies the current level and also the next one advances only one level.
- R6: Control register, address 2**AW-1. Bits [LW-1:0] hold the level count, where LW = clog2(MAXLVL+1); this is bits [3:0] by default. A count of 0 acts as 1, and a count above MAXLVL acts as MAXLVL.
- R7: When the final level holds, `armed` drops to 0. `level` then stays at the final level, whatever the probes do, until the next `arm`.
- R8: Control bit LW (bit 4 by default) enables trigger-in gating. While it is set, the final level counts only in samples where `trig_in_n` is 0. Earlier levels ignore `trig_in_n`, and with the bit clear `trig_in_n` has no effect.
- R9: For a completing sample taken at the end of cycle k, `trig_out_n` is 0 during cycle k+4 only and 1 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | 2*NSIG | Register write data |
| arm | input | 1 | Restart the chain at level 1 |
| probe | input | NSIG | Probed signals, sampled every clock |
| trig_in_n | input | 1 | External trigger, active low |
| trig_out_n | output | 1 | Trigger event pulse, active low |
| armed | output | 1 | Chain is waiting for its levels |
| level | output | LW | Level currently awaited, counting from 1 |

## Verification
With one level configured, every pattern word for a four-signal bus is swept against every probe value with all signals enabled. This separates each condition code and shows that a single failing bit blocks the level. A second sweep crosses every mask value with every probe value under an all-high pattern, to show masked bits become free. Directed chains over three and ten levels separate in-order, one-step-per-sample advance from skipping. They also cover the hold after completion, the count clamping, the trigger-in gate on the final level alone, and the exact cycle of the output pulse.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;
  localparam int TRIG_LAT = 4;

  typedef enum logic [1:0] {
    COND_FREE = 2'b00,
    COND_LOW  = 2'b01,
    COND_HIGH = 2'b10,
    COND_RSV  = 2'b11
  } cond_e;

  function automatic logic cond_ok(input logic [1:0] code, input logic bit_v);
    logic r;
    case (code)
      COND_LOW:  r = ~bit_v;
      COND_HIGH: r = bit_v;
      default:   r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/seqtrig_cfg.sv
module seqtrig_cfg #(
  parameter int NSIG   = 8,
  parameter int MAXLVL = 10,
  parameter int AW     = 4,
  parameter int LW     = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cfg_we,
  input  logic [AW-1:0]                       cfg_addr,
  input  logic [2*NSIG-1:0]                   cfg_wdata,
  output logic [MAXLVL-1:0][2*NSIG-1:0]       pat,
  output logic [NSIG-1:0]                     mask,
  output logic [LW-1:0]                       last_idx,
  output logic                                tin_en
);
  localparam logic [AW-1:0] ADDR_MASK = AW'((2 ** AW) - 2);
  localparam logic [AW-1:0] ADDR_CTRL = AW'((2 ** AW) - 1);

  logic [LW-1:0] cnt_w;
  logic [LW-1:0] last_w;

  assign cnt_w = cfg_wdata[LW-1:0];

  always_comb begin
    if (cnt_w == '0)              last_w = '0;
    else if (cnt_w > LW'(MAXLVL)) last_w = LW'(MAXLVL - 1);
    else                          last_w = cnt_w - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pat      <= '0;
      mask     <= '0;
      last_idx <= '0;
      tin_en   <= 1'b0;
    end else if (cfg_we) begin
      for (int a = 0; a < MAXLVL; a++) begin
        if (cfg_addr == AW'(a)) pat[a] <= cfg_wdata;
      end
      if (cfg_addr == ADDR_MASK) mask <= cfg_wdata[NSIG-1:0];
      if (cfg_addr == ADDR_CTRL) begin
        last_idx <= last_w;
        tin_en   <= cfg_wdata[LW];
      end
    end
  end
endmodule

// File: rtl/seqtrig_match.sv
module seqtrig_match #(
  parameter int NSIG = 8
) (
  input  logic [2*NSIG-1:0] pat_sel,
  input  logic [NSIG-1:0]   mask,
  input  logic [NSIG-1:0]   probe,
  output logic              hit
);
  import seqtrig_pkg::*;

  logic [NSIG-1:0] ok;

  for (genvar i = 0; i < NSIG; i++) begin : g_sig
    assign ok[i] = ~mask[i] | cond_ok(pat_sel[2*i +: 2], probe[i]);
  end

  assign hit = &ok;
endmodule

// File: rtl/seqtrig_seq.sv
module seqtrig_seq #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          lvl_hit,
  input  logic [LW-1:0] last_idx,
  input  logic          tin_en,
  input  logic          trig_in_n,
  output logic          armed,
  output logic [LW-1:0] lvl,
  output logic          fire
);
  logic at_last;
  logic gate_ok;
  logic step;

  assign at_last = (lvl >= last_idx);
  assign gate_ok = ~at_last | ~tin_en | ~trig_in_n;
  assign step    = armed & ~arm & lvl_hit & gate_ok;
  assign fire    = step & at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      lvl   <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      lvl   <= '0;
    end else if (step) begin
      if (at_last) armed <= 1'b0;
      else         lvl   <= lvl + LW'(1);
    end
  end
endmodule

// File: rtl/seqtrig_delay.sv
module seqtrig_delay #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout_n
);
  logic [DEPTH-1:0] sr;

  if (DEPTH == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= din;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= {sr[DEPTH-2:0], din};
    end
  end

  assign dout_n = ~sr[DEPTH-1];
endmodule

// File: rtl/seqtrig_top.sv
module seqtrig_top #(
  parameter int NSIG   = 8,
  parameter int MAXLVL = 10,
  parameter int AW     = 4,
  localparam int WW    = 2 * NSIG,
  localparam int LW    = $clog2(MAXLVL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [WW-1:0] cfg_wdata,
  input  logic          arm,
  input  logic [NSIG-1:0] probe,
  input  logic          trig_in_n,
  output logic          trig_out_n,
  output logic          armed,
  output logic [LW-1:0] level
);
  import seqtrig_pkg::*;

  logic [MAXLVL-1:0][WW-1:0] pat;
  logic [NSIG-1:0]           mask;
  logic [LW-1:0]             last_idx;
  logic                      tin_en;
  logic [LW-1:0]             lvl;
  logic [WW-1:0]             pat_sel;
  logic                      lvl_hit;
  logic                      fire;

  seqtrig_cfg #(.NSIG(NSIG), .MAXLVL(MAXLVL), .AW(AW), .LW(LW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pat(pat), .mask(mask),
    .last_idx(last_idx), .tin_en(tin_en)
  );

  always_comb begin
    pat_sel = '0;
    for (int a = 0; a < MAXLVL; a++) begin
      if (lvl == LW'(a)) pat_sel = pat[a];
    end
  end

  seqtrig_match #(.NSIG(NSIG)) u_match (
    .pat_sel(pat_sel), .mask(mask), .probe(probe), .hit(lvl_hit)
  );

  seqtrig_seq #(.LW(LW)) u_seq (
    .clk(clk), .rst(rst), .arm(arm), .lvl_hit(lvl_hit),
    .last_idx(last_idx), .tin_en(tin_en), .trig_in_n(trig_in_n),
    .armed(armed), .lvl(lvl), .fire(fire)
  );

  seqtrig_delay #(.DEPTH(TRIG_LAT)) u_dly (
    .clk(clk), .rst(rst), .din(fire), .dout_n(trig_out_n)
  );

  assign level = lvl + LW'(1);
endmodule

// File: rtl/seqtrig_chk.sv
module seqtrig_chk #(
  parameter int MAXLVL = 10,
  parameter int LW     = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          arm,
  input logic          armed,
  input logic [LW-1:0] level,
  input logic          trig_out_n,
  input logic          fire
);
  import seqtrig_pkg::*;

  AST_ARM_RESTART: assert property (@(posedge clk) disable iff (rst)
    arm |=> (armed && level == LW'(1))); // R2

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (level == $past(level) || level == $past(level) + LW'(1))); // R5

  AST_HOLD_DONE: assert property (@(posedge clk) disable iff (rst)
    (!armed && !arm) |=> (!armed && $stable(level))); // R7

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (level >= LW'(1) && level <= LW'(MAXLVL))); // R6

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (!trig_out_n) == $past(fire, TRIG_LAT)); // R9

  AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !trig_out_n |=> trig_out_n); // R9
endmodule

bind seqtrig_top seqtrig_chk #(.MAXLVL(MAXLVL), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .arm(arm), .armed(armed), .level(level),
  .trig_out_n(trig_out_n), .fire(fire)
);

// File: tb/seqtrig_top_bench.sv
module seqtrig_top_bench;
  localparam int NSIG = 4;
  localparam int MAXLVL = 10;
  localparam int AW = 4;
  localparam int WW = 2 * NSIG;
  localparam int LW = 4;
  localparam logic [AW-1:0] A_MASK = 4'd14;
  localparam logic [AW-1:0] A_CTRL = 4'd15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [WW-1:0] cfg_wdata = '0;
  logic arm = 1'b0;
  logic [NSIG-1:0] probe = '0;
  logic trig_in_n = 1'b1;
  logic trig_out_n;
  logic armed;
  logic [LW-1:0] level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seqtrig_top #(.NSIG(NSIG), .MAXLVL(MAXLVL), .AW(AW)) u_seqtrig_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .arm(arm), .probe(probe), .trig_in_n(trig_in_n),
    .trig_out_n(trig_out_n), .armed(armed), .level(level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic smp(input logic [NSIG-1:0] v);
    probe = v;
    @(negedge clk);
  endtask

  function automatic bit want_hit(input logic [WW-1:0] p, input logic [NSIG-1:0] m,
                                  input logic [NSIG-1:0] v);
    bit r = 1'b1;
    for (int i = 0; i < NSIG; i++) begin
      int code = int'(p[2*i +: 2]);
      if (m[i]) begin
        if (code == 1 && v[i] != 1'b0) r = 1'b0;
        if (code == 2 && v[i] != 1'b1) r = 1'b0;
      end
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(trig_out_n == 1'b1, "R1 trig_out_n", int'(trig_out_n), 1);
    check(armed == 1'b0, "R1 armed", int'(armed), 0);
    check(level == 4'd1, "R1 level", int'(level), 1);

    // R3 sweep: every pattern word against every probe value, all enabled
    wr(A_CTRL, 8'h01);
    wr(A_MASK, 8'h0F);
    for (int p = 0; p < 256; p++) begin
      wr(4'd0, WW'(p));
      for (int v = 0; v < 16; v++) begin
        bit e;
        do_arm();
        smp(NSIG'(v));
        e = want_hit(WW'(p), 4'hF, NSIG'(v));
        check(armed == !e, "R3 condition codes", int'(armed), int'(!e));
      end
    end

    // R4 sweep: every mask value under an all-high pattern
    wr(4'd0, 8'hAA);
    for (int m = 0; m < 16; m++) begin
      wr(A_MASK, WW'(m));
      for (int v = 0; v < 16; v++) begin
        bit e;
        do_arm();
        smp(NSIG'(v));
        e = (((v | ~m) & 15) == 15);
        check(armed == !e, "R4 mask", int'(armed), int'(!e));
      end
    end

    // R5/R7/R9 three-level chain: sig0 high, sig1 high, sig2 high
    wr(A_MASK, 8'h0F);
    wr(4'd0, 8'h02);
    wr(4'd1, 8'h08);
    wr(4'd2, 8'h20);
    wr(A_CTRL, 8'h03);
    do_arm();
    check(armed == 1'b1 && level == 4'd1, "R2 arm", int'(level), 1);
    smp(4'h1);
    check(level == 4'd2, "R5 advance", int'(level), 2);
    smp(4'h1);
    check(level == 4'd2, "R5 wait in order", int'(level), 2);
    smp(4'h7);
    check(level == 4'd3, "R5 one step per sample", int'(level), 3);
    smp(4'h7);
    check(armed == 1'b0, "R7 fired", int'(armed), 0);
    check(level == 4'd3, "R7 level holds", int'(level), 3);
    check(trig_out_n == 1'b1, "R9 cycle k+1", int'(trig_out_n), 1);
    smp(4'h7);
    check(trig_out_n == 1'b1, "R9 cycle k+2", int'(trig_out_n), 1);
    smp(4'h7);
    check(trig_out_n == 1'b1, "R9 cycle k+3", int'(trig_out_n), 1);
    smp(4'h7);
    check(trig_out_n == 1'b0, "R9 cycle k+4", int'(trig_out_n), 0);
    smp(4'h7);
    check(trig_out_n == 1'b1, "R9 cycle k+5", int'(trig_out_n), 1);
    check(armed == 1'b0 && level == 4'd3, "R7 no restart", int'(level), 3);

    // R2 arm mid-chain
    do_arm();
    smp(4'h1);
    check(level == 4'd2, "R2 setup", int'(level), 2);
    probe = 4'h7;
    do_arm();
    check(armed == 1'b1 && level == 4'd1, "R2 arm overrides match", int'(level), 1);

    // R6 count 0 acts as 1
    wr(A_CTRL, 8'h00);
    do_arm();
    smp(4'h1);
    check(armed == 1'b0, "R6 count zero", int'(armed), 0);

    // R6 count 15 acts as 10
    for (int a = 0; a < MAXLVL; a++) wr(AW'(a), 8'h02);
    wr(A_CTRL, 8'h0F);
    do_arm();
    for (int i = 0; i < MAXLVL - 1; i++) begin
      smp(4'h1);
      check(armed == 1'b1 && level == LW'(i + 2), "R6 clamp progress", int'(level), i + 2);
    end
    smp(4'h1);
    check(armed == 1'b0 && level == 4'd10, "R6 clamp fire at 10", int'(level), 10);

    // R8 trigger-in gate
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h00);
    wr(A_CTRL, 8'h11);
    do_arm();
    trig_in_n = 1'b1;
    smp(4'h0);
    check(armed == 1'b1, "R8 gated high", int'(armed), 1);
    trig_in_n = 1'b0;
    smp(4'h0);
    check(armed == 1'b0, "R8 fires when low", int'(armed), 0);
    trig_in_n = 1'b1;
    wr(A_CTRL, 8'h12);
    do_arm();
    smp(4'h0);
    check(level == 4'd2 && armed == 1'b1, "R8 early level ungated", int'(level), 2);
    smp(4'h0);
    check(armed == 1'b1, "R8 final gated", int'(armed), 1);
    trig_in_n = 1'b0;
    smp(4'h0);
    check(armed == 1'b0, "R8 final passes", int'(armed), 0);
    trig_in_n = 1'b1;
    wr(A_CTRL, 8'h01);
    do_arm();
    smp(4'h0);
    check(armed == 1'b0, "R8 gating off ignores input", int'(armed), 0);

    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule